// File: doc/BRIEF.md
# Pipe Buffer Readiness Tracker

This block follows the state of one pipe's FIFO buffer, built from one plane or from two planes used alternately, and turns that state into a single ready flag for the processor side. The storage itself is not modelled. The bus side and the processor side each report a finished plane through a one-cycle event. The block keeps a full bit per plane and a pointer for each side. It also keeps a transaction counter that can limit how many receive packets are accepted.

A direction input selects receive or transmit. In receive, the flag means data is waiting to be read. In transmit, it means a plane has room for new data. A mode bit sets how the receive flag is released:
- In the normal mode, the flag drops when the last data has been read.
- In the hold mode, the flag stays high until software strobes a buffer clear after that final read.

Some mode combinations are not allowed. Any of them raises a sticky error and freezes the block until a pipe-wide clear. The pipe-wide clear returns every piece of state to its reset value.

Top module: `usb_pipe_bufstat`

## Requirements
- R1: After reset every plane is empty, both plane pointers read 0, `mode_err` is 0, the transaction counter reads 0 and is inactive (`tc_stop`=0), and `buf_rdy` reads 0 in receive (`dir_tx`=0) and 1 in transmit (`dir_tx`=1).
- R2: In receive with `hold_mode`=0 (with `auto_clr` either 0 or 1), a `bus_done` into an empty plane fills it and `buf_rdy` reads 1. A `cpu_done` on a full plane empties it, and `buf_rdy` reads 0 once no active plane is full.
- R3: In receive with `hold_mode`=1 and `auto_clr`=0, `buf_rdy` stays 1 after the last plane has been read. It returns to 0 only on a `sw_clear` issued after that read. A `sw_clear` while data is still unread has no effect.
- R4: In transmit with both mode bits 0, `cpu_done` fills the processor plane and `bus_done` empties the bus plane. `buf_rdy` is 1 while any active plane is empty and 0 when all active planes are full.
- R5: Receive with `hold_mode`=1 and `auto_clr`=1 is illegal, and so is transmit with either mode bit at 1. In an illegal combination `buf_rdy` reads 0 at once and `mode_err` is 1 from the next clock edge. `mode_err` stays 1 after the mode becomes legal again.
- R6: While `mode_err` is 1, `bus_done`, `cpu_done`, `sw_clear` and `tc_load` change no state: the plane pointers, the full bits and `tc_left` stay as they were.
- R7: With `dbl_buf`=1, each accepted event on one side moves that side's pointer to the other plane (0, 1, 0, ...). A fill aimed at a plane that is already full is ignored. The receive flag is 1 while either plane is full.
- R8: With `dbl_buf`=0, only plane 0 is used and both pointers stay at 0. A second receive fill before a read is ignored.
- R9: `tc_load` loads `tc_value` and activates the counter. A fill in the same cycle as `tc_load` is ignored. Each accepted receive fill decrements the counter while it is active. At 0, `tc_stop` reads 1 and receive fills are ignored until a new load.
- R10: `pipe_clear` has priority over every event in the same cycle. On the next edge it returns all state, including `mode_err`, to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_tx | input | 1 | 0 = receive pipe, 1 = transmit pipe |
| hold_mode | input | 1 | Receive flag stays high until software clear |
| auto_clr | input | 1 | Automatic clear after read |
| dbl_buf | input | 1 | 1 = two planes used alternately |
| bus_done | input | 1 | Bus side finished a plane (fill in receive, send in transmit) |
| cpu_done | input | 1 | Processor side finished a plane (read in receive, write in transmit) |
| sw_clear | input | 1 | Software buffer-clear strobe |
| pipe_clear | input | 1 | Pipe-wide clear strobe |
| tc_load | input | 1 | Load the transaction counter |
| tc_value | input | TCW | Value to load into the transaction counter |
| buf_rdy | output | 1 | Buffer ready for the processor side |
| mode_err | output | 1 | Sticky illegal-mode error |
| cpu_plane | output | PW | Plane the processor side works on |
| bus_plane | output | PW | Plane the bus side works on |
| plane_full | output | NPL | Full bit of each plane |
| tc_left | output | TCW | Transaction counter value |
| tc_stop | output | 1 | Counter active and exhausted |

## Verification
Every registered result (full bits, pointers, `mode_err`, counter) is due one clock edge after the event that causes it. `buf_rdy` is combinational from that state and the current mode inputs, so an illegal mode forces it low in the same cycle, before `mode_err` rises at the next edge. The bench drives each step just after a falling edge and samples at the next falling edge. Each check therefore sees the state that the single intervening rising edge produced, while the mode inputs of that step are still applied.

// File: rtl/usb_bufstat_pkg.sv
package usb_bufstat_pkg;

  function automatic logic mode_bad(input logic tx, input logic hold, input logic autoc);
    return tx ? (hold | autoc) : (hold & autoc);
  endfunction

  function automatic int unsigned next_plane(input int unsigned cur, input logic dbl,
                                             input int unsigned nplanes);
    if (!dbl) return 0;
    return (cur == nplanes - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/usb_bufstat_mode.sv
module usb_bufstat_mode
  import usb_bufstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pipe_clear,
  input  logic dir_tx,
  input  logic hold_mode,
  input  logic auto_clr,
  output logic bad_now,
  output logic err_q,
  output logic hold_md
);
  assign bad_now = mode_bad(dir_tx, hold_mode, auto_clr);
  assign hold_md = !dir_tx && hold_mode && !auto_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (pipe_clear) err_q <= 1'b0;
    else if (bad_now)    err_q <= 1'b1;
  end
endmodule

// File: rtl/usb_bufstat_tcnt.sv
module usb_bufstat_tcnt #(
  parameter int TCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pipe_clear,
  input  logic           blk,
  input  logic           tc_load,
  input  logic [TCW-1:0] tc_value,
  input  logic           fill_acc,
  output logic [TCW-1:0] tc_left,
  output logic           tc_stop,
  output logic           tc_dec
);
  logic           act_q;
  logic [TCW-1:0] cnt_q;

  assign tc_stop = act_q && (cnt_q == '0);
  assign tc_dec  = fill_acc && act_q;
  assign tc_left = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (pipe_clear) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!blk) begin
      if (tc_load) begin
        act_q <= 1'b1;
        cnt_q <= tc_value;
      end else if (tc_dec) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_bufstat_planes.sv
module usb_bufstat_planes
  import usb_bufstat_pkg::*;
#(
  parameter int NPL = 2,
  localparam int PW = (NPL > 1) ? $clog2(NPL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pipe_clear,
  input  logic           blk,
  input  logic           dir_tx,
  input  logic           dbl_buf,
  input  logic           hold_md,
  input  logic           bus_done,
  input  logic           cpu_done,
  input  logic           sw_clear,
  input  logic           tc_stop,
  input  logic           tc_load,
  output logic [NPL-1:0] full_q,
  output logic [PW-1:0]  bptr_q,
  output logic [PW-1:0]  cptr_q,
  output logic           hold_q,
  output logic           fill_acc,
  output logic           drain_acc,
  output logic           wr_acc,
  output logic           snd_acc,
  output logic           any_full,
  output logic           any_empty
);
  logic           bus_hit, cpu_hit, bus_adv, cpu_adv, hold_set;
  logic [NPL-1:0] full_nxt, act_mask;

  assign bus_hit   = full_q[bptr_q];
  assign cpu_hit   = full_q[cptr_q];
  assign fill_acc  = !blk && !dir_tx && bus_done && !bus_hit && !tc_stop && !tc_load;
  assign drain_acc = !blk && !dir_tx && cpu_done && cpu_hit;
  assign wr_acc    = !blk && dir_tx && cpu_done && !cpu_hit;
  assign snd_acc   = !blk && dir_tx && bus_done && bus_hit;
  assign bus_adv   = fill_acc || snd_acc;
  assign cpu_adv   = drain_acc || wr_acc;

  for (genvar i = 0; i < NPL; i++) begin : g_plane
    logic set_i, clr_i;
    assign act_mask[i] = (i == 0) || dbl_buf;
    assign set_i = (fill_acc && bptr_q == PW'(i)) || (wr_acc  && cptr_q == PW'(i));
    assign clr_i = (drain_acc && cptr_q == PW'(i)) || (snd_acc && bptr_q == PW'(i));
    assign full_nxt[i] = set_i ? 1'b1 : (clr_i ? 1'b0 : full_q[i]);
  end

  assign any_full  = |(full_q & act_mask);
  assign any_empty = |(~full_q & act_mask);
  assign hold_set  = drain_acc && hold_md && ((full_nxt & act_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      bptr_q <= '0;
      cptr_q <= '0;
      hold_q <= 1'b0;
    end else if (pipe_clear) begin
      full_q <= '0;
      bptr_q <= '0;
      cptr_q <= '0;
      hold_q <= 1'b0;
    end else if (!blk) begin
      full_q <= full_nxt;
      if (bus_adv) bptr_q <= PW'(next_plane(int'(bptr_q), dbl_buf, NPL));
      if (cpu_adv) cptr_q <= PW'(next_plane(int'(cptr_q), dbl_buf, NPL));
      if (hold_set)                hold_q <= 1'b1;
      else if (sw_clear && hold_q) hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_pipe_bufstat.sv
module usb_pipe_bufstat #(
  parameter int NPL = 2,
  parameter int TCW = 8,
  localparam int PW = (NPL > 1) ? $clog2(NPL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir_tx,
  input  logic           hold_mode,
  input  logic           auto_clr,
  input  logic           dbl_buf,
  input  logic           bus_done,
  input  logic           cpu_done,
  input  logic           sw_clear,
  input  logic           pipe_clear,
  input  logic           tc_load,
  input  logic [TCW-1:0] tc_value,
  output logic           buf_rdy,
  output logic           mode_err,
  output logic [PW-1:0]  cpu_plane,
  output logic [PW-1:0]  bus_plane,
  output logic [NPL-1:0] plane_full,
  output logic [TCW-1:0] tc_left,
  output logic           tc_stop
);
  logic bad_now, hold_md, blk, hold_q;
  logic fill_acc, drain_acc, wr_acc, snd_acc, any_full, any_empty, tc_dec;

  usb_bufstat_mode u_mode (
    .clk(clk), .rst_n(rst_n), .pipe_clear(pipe_clear), .dir_tx(dir_tx),
    .hold_mode(hold_mode), .auto_clr(auto_clr), .bad_now(bad_now),
    .err_q(mode_err), .hold_md(hold_md)
  );

  assign blk = bad_now || mode_err;

  usb_bufstat_planes #(.NPL(NPL)) u_planes (
    .clk(clk), .rst_n(rst_n), .pipe_clear(pipe_clear), .blk(blk),
    .dir_tx(dir_tx), .dbl_buf(dbl_buf), .hold_md(hold_md),
    .bus_done(bus_done), .cpu_done(cpu_done), .sw_clear(sw_clear),
    .tc_stop(tc_stop), .tc_load(tc_load), .full_q(plane_full),
    .bptr_q(bus_plane), .cptr_q(cpu_plane), .hold_q(hold_q),
    .fill_acc(fill_acc), .drain_acc(drain_acc), .wr_acc(wr_acc),
    .snd_acc(snd_acc), .any_full(any_full), .any_empty(any_empty)
  );

  usb_bufstat_tcnt #(.TCW(TCW)) u_tcnt (
    .clk(clk), .rst_n(rst_n), .pipe_clear(pipe_clear), .blk(blk),
    .tc_load(tc_load), .tc_value(tc_value), .fill_acc(fill_acc),
    .tc_left(tc_left), .tc_stop(tc_stop), .tc_dec(tc_dec)
  );

  assign buf_rdy = !blk && (dir_tx ? any_empty : (any_full || (hold_md && hold_q)));
endmodule

// File: rtl/usb_bufstat_chk.sv
module usb_bufstat_chk #(
  parameter int NPL = 2,
  parameter int TCW = 8,
  parameter int PW  = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pipe_clear,
  input logic           sw_clear,
  input logic           tc_load,
  input logic           dbl_buf,
  input logic           mode_err,
  input logic           buf_rdy,
  input logic           hold_q,
  input logic           fill_acc,
  input logic           tc_stop,
  input logic [NPL-1:0] plane_full,
  input logic [PW-1:0]  cpu_plane,
  input logic [PW-1:0]  bus_plane,
  input logic [TCW-1:0] tc_left
);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err && !pipe_clear |=> mode_err);

  p_rdy_low_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !buf_rdy);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err && !pipe_clear |=> $stable(plane_full) && $stable(cpu_plane)
                                && $stable(bus_plane) && $stable(tc_left));

  p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !sw_clear && !pipe_clear |=> hold_q);

  p_single_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_buf && fill_acc && !pipe_clear |=> bus_plane == '0);

  p_tc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_stop && !tc_load && !pipe_clear |=> tc_stop && $stable(tc_left));

  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_clear |=> plane_full == '0 && !mode_err && tc_left == '0 && !tc_stop
                   && cpu_plane == '0 && bus_plane == '0);
endmodule

bind usb_pipe_bufstat usb_bufstat_chk #(.NPL(NPL), .TCW(TCW), .PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .pipe_clear(pipe_clear), .sw_clear(sw_clear),
  .tc_load(tc_load), .dbl_buf(dbl_buf), .mode_err(mode_err), .buf_rdy(buf_rdy),
  .hold_q(hold_q), .fill_acc(fill_acc), .tc_stop(tc_stop),
  .plane_full(plane_full), .cpu_plane(cpu_plane), .bus_plane(bus_plane),
  .tc_left(tc_left)
);

// File: tb/test_usb_pipe_bufstat.sv
module test_usb_pipe_bufstat;
  localparam int CLK_PER = 10;
  localparam int TCW = 8;
  localparam int NPL = 2;
  localparam int NROW = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_tx = 0, hold_mode = 0, auto_clr = 0, dbl_buf = 0;
  logic bus_done = 0, cpu_done = 0, sw_clear = 0, pipe_clear = 0, tc_load = 0;
  logic [TCW-1:0] tc_value = '0;
  logic buf_rdy, mode_err, tc_stop;
  logic [0:0] cpu_plane, bus_plane;
  logic [NPL-1:0] plane_full;
  logic [TCW-1:0] tc_left;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  usb_pipe_bufstat #(.NPL(NPL), .TCW(TCW)) i_usb_pipe_bufstat (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .hold_mode(hold_mode),
    .auto_clr(auto_clr), .dbl_buf(dbl_buf), .bus_done(bus_done),
    .cpu_done(cpu_done), .sw_clear(sw_clear), .pipe_clear(pipe_clear),
    .tc_load(tc_load), .tc_value(tc_value), .buf_rdy(buf_rdy),
    .mode_err(mode_err), .cpu_plane(cpu_plane), .bus_plane(bus_plane),
    .plane_full(plane_full), .tc_left(tc_left), .tc_stop(tc_stop)
  );

  // Row: req[13:10] dir hold auto dbl bus cpu swc pclr [9:2], exp_rdy exp_err [1:0]
  localparam logic [13:0] VEC [NROW] = '{
    {4'd2,  8'b0000_1000, 2'b10},  // R2 receive fill
    {4'd8,  8'b0000_1000, 2'b10},  // R8 second fill ignored
    {4'd2,  8'b0000_0100, 2'b00},  // R2 read empties
    {4'd2,  8'b0010_1000, 2'b10},  // R2 auto_clr=1 fill
    {4'd2,  8'b0010_0100, 2'b00},  // R2 auto_clr=1 read
    {4'd3,  8'b0100_1000, 2'b10},  // R3 hold-mode fill
    {4'd3,  8'b0100_0010, 2'b10},  // R3 early sw_clear no effect
    {4'd3,  8'b0100_0100, 2'b10},  // R3 read, flag held
    {4'd3,  8'b0100_0000, 2'b10},  // R3 still held
    {4'd3,  8'b0100_0010, 2'b00},  // R3 sw_clear releases
    {4'd7,  8'b0001_1000, 2'b10},  // R7 fill plane 0
    {4'd7,  8'b0001_1000, 2'b10},  // R7 fill plane 1
    {4'd7,  8'b0001_1000, 2'b10},  // R7 overrun ignored
    {4'd7,  8'b0001_0100, 2'b10},  // R7 read plane 0, plane 1 left
    {4'd7,  8'b0001_0100, 2'b00},  // R7 read plane 1
    {4'd4,  8'b1001_0000, 2'b10},  // R4 transmit, both empty
    {4'd4,  8'b1001_0100, 2'b10},  // R4 one written
    {4'd4,  8'b1001_0100, 2'b00},  // R4 both written
    {4'd4,  8'b1001_1000, 2'b10},  // R4 one sent
    {4'd10, 8'b1001_0001, 2'b10},  // R10 pipe clear
    {4'd4,  8'b1000_0100, 2'b00},  // R4 single written
    {4'd4,  8'b1000_1000, 2'b10},  // R4 single sent
    {4'd5,  8'b1100_0000, 2'b01},  // R5 illegal transmit mode
    {4'd6,  8'b1000_0100, 2'b01},  // R6 legal again, still frozen
    {4'd10, 8'b1000_0001, 2'b10}   // R10 clear removes error
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    bus_done = 0; cpu_done = 0; sw_clear = 0; pipe_clear = 0; tc_load = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "buf_rdy rx", buf_rdy, 0);
    chk("R1", "mode_err", mode_err, 0);
    chk("R1", "planes", plane_full, 0);
    chk("R1", "ptrs", {cpu_plane, bus_plane}, 0);
    chk("R1", "tc_left", tc_left, 0);
    chk("R1", "tc_stop", tc_stop, 0);
    dir_tx = 1; #1;
    chk("R1", "buf_rdy tx", buf_rdy, 1);
    dir_tx = 0;

    for (int r = 0; r < NROW; r++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VEC[r][13:10], r);
      {dir_tx, hold_mode, auto_clr, dbl_buf} = VEC[r][9:6];
      {bus_done, cpu_done, sw_clear, pipe_clear} = VEC[r][5:2];
      cyc();
      chk(tag, "buf_rdy", buf_rdy, VEC[r][1]);
      chk(tag, "mode_err", mode_err, VEC[r][0]);
    end

    // R7 pointer alternation
    dir_tx = 0; hold_mode = 0; auto_clr = 0; dbl_buf = 1;
    bus_done = 1; cyc();
    chk("R7", "bus_plane after 1 fill", bus_plane, 1);
    bus_done = 1; cyc();
    chk("R7", "bus_plane after 2 fills", bus_plane, 0);
    chk("R7", "full bits", plane_full, 3);
    cpu_done = 1; cyc();
    chk("R7", "cpu_plane after read", cpu_plane, 1);
    chk("R7", "full bits after read", plane_full, 2);

    // R8 single plane pointers
    pipe_clear = 1; cyc();
    dbl_buf = 0;
    bus_done = 1; cyc();
    bus_done = 1; cyc();
    chk("R8", "bus_plane single", bus_plane, 0);
    chk("R8", "full bits single", plane_full, 1);

    // R5 illegal receive combination, R6 events frozen
    pipe_clear = 1; cyc();
    hold_mode = 1; auto_clr = 1; #1;
    chk("R5", "buf_rdy same cycle", buf_rdy, 0);
    cyc();
    chk("R5", "mode_err rx illegal", mode_err, 1);
    hold_mode = 0; auto_clr = 0;
    bus_done = 1; tc_load = 1; tc_value = 8'd5; cyc();
    chk("R6", "full bits frozen", plane_full, 0);
    chk("R6", "bus_plane frozen", bus_plane, 0);
    chk("R6", "tc_left frozen", tc_left, 0);

    // R10 clear beats same-cycle events
    pipe_clear = 1; bus_done = 1; tc_load = 1; tc_value = 8'd7; cyc();
    chk("R10", "mode_err cleared", mode_err, 0);
    chk("R10", "full bits", plane_full, 0);
    chk("R10", "tc_left", tc_left, 0);
    chk("R10", "buf_rdy", buf_rdy, 0);

    // R9 transaction counter
    tc_load = 1; tc_value = 8'd2; bus_done = 1; cyc();
    chk("R9", "fill ignored in load cycle", plane_full, 0);
    chk("R9", "loaded", tc_left, 2);
    bus_done = 1; cyc();
    chk("R9", "after fill 1", tc_left, 1);
    cpu_done = 1; cyc();
    bus_done = 1; cyc();
    chk("R9", "after fill 2", tc_left, 0);
    chk("R9", "tc_stop", tc_stop, 1);
    cpu_done = 1; cyc();
    bus_done = 1; cyc();
    chk("R9", "fill blocked", buf_rdy, 0);
    tc_load = 1; tc_value = 8'd1; cyc();
    bus_done = 1; cyc();
    chk("R9", "fill after reload", buf_rdy, 1);
    chk("R9", "tc after reload fill", tc_left, 0);

    finish_run();
  end
endmodule